// File: doc/BRIEF.md
# Four-Lane Transmit Octet Mapper (8 Octets per Frame)

This block sits between a streaming sample source and the data-link layer of a multi-lane serial converter link. It accepts one 256-bit sample word through a ready/valid handshake, holds it, and spreads its 32 octets over four lanes. Each lane carries eight octets per frame on a 32-bit interface, so every frame leaves the block in two beats of the link clock.

The octet layout does not depend on how the 16 sample slots are split between converters and samples per converter (any split with a product of 16). The mapper moves octets only, and sample 0 of a one-converter, sixteen-sample frame arrives in the lowest 16 bits of the input. Once the source has delivered its first word, it must present a new word whenever ready is offered. A missing word is reported to the link layer as a sticky error, and lane data is marked invalid from that point on.

Top module: `jtl_tx_mapper`

## Requirements
- R1: While rst_ni is low, all lane outputs are zero, link_valid_o and link_err_o are low, and ready_o is high.
- R2: ready_o is high only when no word is held, or when the final (second) beat of the held word is on the lanes, and never while link_err_o is high. A word is captured on a clock edge where valid_i and ready_o are both high.
- R3: Input octet n (0..31) sits in sample pair n/2 at bits [16*(n/2)+15 : 16*(n/2)]. An even n takes the upper byte of the pair and an odd n takes the lower byte.
- R4: In the cycle after a capture (beat T0), lane l (bits [32l+31:32l] of lane_data_o) carries octets 8l, 8l+1, 8l+2, 8l+3, with the lowest-numbered octet in bits 31:24.
- R5: In the cycle after T0 (beat T1), lane l carries octets 8l+4 to 8l+7 in the same byte order.
- R6: link_valid_o is high during both beats of every held word, and a word captured during T1 follows at once, with no gap.
- R7: If valid_i is low while ready_o is high after at least one word has been captured, link_err_o goes high in the next cycle and link_valid_o goes low.
- R8: link_err_o stays high until reset. While it is high, ready_o stays low, and data_i and valid_i leave the lane outputs unchanged.
- R9: Before the first word after reset has been captured, valid_i low is not an error.
- R10: valid_i and data_i are ignored in the T0 cycle, when ready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 256 | Sample word from the source |
| valid_i | input | 1 | Source has a word on data_i |
| ready_o | output | 1 | Mapper takes a word this cycle |
| lane_data_o | output | 128 | Four 32-bit lane words, lane 0 in the lowest bits |
| link_valid_o | output | 1 | Lane words are valid for the link layer |
| link_err_o | output | 1 | Sticky flag: a word was missing while ready was offered |

## Verification
The assertions assume that the source drives valid_i and data_i steadily between clock edges, and that after the first capture any low valid_i under ready_o is a real dropout, not a deliberate pause. The stimulus changes inputs only at falling edges. It keeps valid_i high whenever ready_o is offered during a stream and drops it only at the one point where an error is intended. Garbage data and a low valid_i are placed only in T0 cycles, where the handshake ignores them. The pre-stream case holds valid_i low with ready_o high before any capture.

// File: rtl/jtl_pkg.sv
package jtl_pkg;
  localparam int LANES_DEF     = 4;
  localparam int OCTETS_DEF    = 8;
  localparam int LANE_W_DEF    = 32;
  localparam int OCT_PER_SMPL  = 2;

  // bit offset of octet n in the input word: pairs from LSB, even octet high
  function automatic int octet_pos(input int n);
    return 16 * (n / OCT_PER_SMPL) + 8 * (OCT_PER_SMPL - 1 - (n % OCT_PER_SMPL));
  endfunction
endpackage

// File: rtl/jtl_frame_hold.sv
module jtl_frame_hold #(
  parameter int IN_W   = 256,
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   data_i,
  input  logic              take_i,
  input  logic              stall_i,
  output logic [IN_W-1:0]   word_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              loaded_o,
  output logic              last_o
);
  logic [IN_W-1:0]   word_q;
  logic [BEAT_W-1:0] beat_q;
  logic              loaded_q;

  assign last_o = (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      beat_q   <= '0;
      loaded_q <= 1'b0;
    end else if (take_i) begin
      word_q   <= data_i;
      beat_q   <= '0;
      loaded_q <= 1'b1;
    end else if (loaded_q && !last_o && !stall_i) begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign word_o   = word_q;
  assign beat_o   = beat_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/jtl_flow_mon.sv
module jtl_flow_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic loaded_i,
  input  logic last_i,
  output logic ready_o,
  output logic take_o,
  output logic err_o,
  output logic link_valid_o
);
  logic err_q;

  assign ready_o      = !err_q && (!loaded_i || last_i);
  assign take_o       = ready_o && valid_i;
  assign link_valid_o = loaded_i && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           err_q <= 1'b0;
    else if (ready_o && !valid_i && loaded_i) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/jtl_lane_mux.sv
module jtl_lane_mux #(
  parameter int LANES  = 4,
  parameter int OCTETS = 8,
  parameter int LANE_W = 32,
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1,
  parameter int IN_W   = 256
) (
  input  logic [IN_W-1:0]        word_i,
  input  logic [BEAT_W-1:0]      beat_i,
  output logic [LANES*LANE_W-1:0] lanes_o
);
  localparam int OPB = LANE_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lw;
    always_comb begin
      lw = '0;
      for (int b = 0; b < BEATS; b++) begin
        if (beat_i == BEAT_W'(b)) begin
          for (int k = 0; k < OPB; k++) begin
            lw[LANE_W-1-8*k -: 8] = word_i[jtl_pkg::octet_pos(l*OCTETS + b*OPB + k) +: 8];
          end
        end
      end
    end
    assign lanes_o[l*LANE_W +: LANE_W] = lw;
  end
endmodule

// File: rtl/jtl_tx_mapper.sv
module jtl_tx_mapper #(
  parameter int LANES  = jtl_pkg::LANES_DEF,
  parameter int OCTETS = jtl_pkg::OCTETS_DEF,
  parameter int LANE_W = jtl_pkg::LANE_W_DEF,
  localparam int IN_W  = LANES * OCTETS * 8,
  localparam int OUT_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic [OUT_W-1:0] lane_data_o,
  output logic             link_valid_o,
  output logic             link_err_o
);
  localparam int BEATS  = (OCTETS * 8) / LANE_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [IN_W-1:0]   word;
  logic [BEAT_W-1:0] beat;
  logic loaded, last, take, err;

  jtl_flow_mon u_flow (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .loaded_i(loaded), .last_i(last),
    .ready_o(ready_o), .take_o(take), .err_o(err), .link_valid_o(link_valid_o)
  );

  jtl_frame_hold #(.IN_W(IN_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .take_i(take), .stall_i(err),
    .word_o(word), .beat_o(beat), .loaded_o(loaded), .last_o(last)
  );

  jtl_lane_mux #(
    .LANES(LANES), .OCTETS(OCTETS), .LANE_W(LANE_W),
    .BEATS(BEATS), .BEAT_W(BEAT_W), .IN_W(IN_W)
  ) u_mux (
    .word_i(word), .beat_i(beat), .lanes_o(lane_data_o)
  );

  assign link_err_o = err;
endmodule

// File: rtl/jtl_tx_mapper_chk.sv
module jtl_tx_mapper_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic link_valid_o,
  input logic link_err_o
);
  // R2: a capture is followed by a T0 cycle without ready
  p_ready_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && valid_i |=> !ready_o);
  // R2/R8: no ready under error
  p_no_ready_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_err_o |-> !ready_o);
  // R8: sticky
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_err_o |=> link_err_o);
  // R7: dropout under ready once streaming
  p_dropout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !valid_i && link_valid_o |=> link_err_o && !link_valid_o);
  // R7: error and valid exclusive
  p_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_err_o |-> !link_valid_o);
  // R9: idle start is not an error
  p_idle_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_valid_o && !link_err_o |=> !link_err_o);
  // R6: a capture makes lane data valid next cycle
  p_take_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && valid_i |=> link_valid_o);
endmodule

bind jtl_tx_mapper jtl_tx_mapper_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .link_valid_o(link_valid_o), .link_err_o(link_err_o)
);

// File: tb/sim_jtl_tx_mapper.sv
`timescale 1ns/1ps
module sim_jtl_tx_mapper;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [255:0] data_i = '0;
  logic         valid_i = 1'b0;
  logic         ready_o, link_valid_o, link_err_o;
  logic [127:0] lane_data_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  jtl_tx_mapper u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .lane_data_o(lane_data_o),
    .link_valid_o(link_valid_o), .link_err_o(link_err_o)
  );

  function automatic logic [7:0] oct(input int w, input int n);
    if (w == 2) return 8'hFF;
    if (w == 3) return 8'h00;
    if (w == 4) return 8'(n);
    return 8'((w * 53 + n * 7 + w * n + 17) & 255);
  endfunction

  // R3 layout built arithmetically
  function automatic logic [255:0] mk_word(input int w);
    logic [255:0] r = '0;
    for (int n = 0; n < 32; n++) r[16 * (n / 2) + (n % 2 == 0 ? 8 : 0) +: 8] = oct(w, n);
    return r;
  endfunction

  function automatic logic [31:0] exp_lane(input int w, input int l, input int b);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[31 - 8 * k -: 8] = oct(w, 8 * l + 4 * b + k);
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_lanes(input string req, input int w, input int b);
    for (int l = 0; l < 4; l++)
      chk(req, 128'(lane_data_o[32 * l +: 32]), 128'(exp_lane(w, l, b)));
  endtask

  // one word through both beats; entered and left at a negedge with ready high
  task automatic send(input int w);
    chk("R2 ready offered", 128'(ready_o), 128'(1));
    data_i = mk_word(w); valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk_lanes("R4/R3 beat T0", w, 0);
    chk("R6 valid T0", 128'(link_valid_o), 128'(1));
    chk("R2 no ready T0", 128'(ready_o), 128'(0));
    data_i = ~mk_word(w + 7); valid_i = w[0]; // R10 garbage in T0
    @(posedge clk_i); @(negedge clk_i);
    chk_lanes("R5/R10 beat T1", w, 1);
    chk("R6 valid T1", 128'(link_valid_o), 128'(1));
    chk("R7 no err", 128'(link_err_o), 128'(0));
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 lanes", lane_data_o, '0);
    chk("R1 valid", 128'(link_valid_o), 128'(0));
    chk("R1 err", 128'(link_err_o), 128'(0));
    chk("R1 ready", 128'(ready_o), 128'(1));
    rst_ni = 1'b1;
    // R9: idle with ready before first word
    repeat (4) @(negedge clk_i);
    chk("R9 no err idle", 128'(link_err_o), 128'(0));
    chk("R9 ready idle", 128'(ready_o), 128'(1));
    for (int w = 0; w < 40; w++) send(w);
    // R7 dropout
    valid_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R7 err", 128'(link_err_o), 128'(1));
    chk("R7 valid low", 128'(link_valid_o), 128'(0));
    // R8 sticky, inputs ignored
    for (int c = 0; c < 6; c++) begin
      data_i = mk_word(100 + c); valid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      chk("R8 err sticky", 128'(link_err_o), 128'(1));
      chk("R8 no ready", 128'(ready_o), 128'(0));
      chk_lanes("R8 lanes hold", 39, 1);
    end
    rst_ni = 1'b0; valid_i = 1'b0;
    @(negedge clk_i);
    chk("R1 lanes again", lane_data_o, '0);
    chk("R1 err cleared", 128'(link_err_o), 128'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int w = 40; w < 44; w++) send(w);
    valid_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R7 err second", 128'(link_err_o), 128'(1));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule